// File: doc/BRIEF.md
# Isochronous Packet Header Checker

This block screens every received isochronous packet that opens with a two-quadlet common isochronous packet header. For each packet it takes the byte length from the isochronous header, the two header quadlets and a set of stream settings. It decides whether the packet belongs to the configured stream and how many data blocks it carries. It also tracks the data block counter from packet to packet, so that a lost or repeated packet is detected.

A packet is presented with a one-cycle strobe. One clock later the block reports the following results:
- the data block count;
- the timestamp field;
- the updated running counter;
- a set of error flags.

The error flags stay set until the stream is restarted. Some faults are fatal: an oversize payload, a zero block size or a counter break. After a fatal fault the checker drops every further packet until a restart pulse. The restart pulse also forgets the running counter, so the first packet of a new stream is taken without a continuity test.

Top module: `cip_rx_check`

## Requirements
- R1: One clock after `pkt_valid` is accepted, `out_valid` is high for exactly one cycle and `out_syt` equals `hdr1[15:0]`. No result is produced while halted or in a cycle where `restart` is high.
- R2: When `pkt_len` exceeds `cfg_max_len`, the packet reports zero blocks, sets `err_oversize` and halts the checker. This check comes before every header check. While halted, no `out_valid` is produced.
- R3: The header framing is bad when `hdr0[31]` is 1 or `hdr1[31]` is 0, unless `cfg_no_eoh` is set. A packet with bad framing sets `err_hdr`, reports zero blocks and leaves the counter unchanged.
- R4: When `hdr0[10]` differs from `cfg_sph`, or `hdr1[29:24]` differs from `cfg_fmt`, the packet sets `err_proto`, reports zero blocks and leaves the counter unchanged.
- R5: The block count is `(pkt_len/4 - 2) / dbs`, where dbs is `hdr0[23:16]`. The count is zero when `pkt_len` < 12, or when `hdr1[29:24]` = 0x10 and `hdr1[23:16]` = 0xFF.
- R6: When a count has to be computed and the received dbs is 0, the packet sets `err_dbs0` and halts the checker. While `cfg_force_dbs` is set, `cfg_dbs` replaces a nonzero received dbs as the divisor.
- R7: The first accepted packet after reset or restart is taken without a continuity test.
- R8: In normal mode (`cfg_end_event`=0), `hdr0[7:0]` must equal the stored counter. The stored counter then becomes `(hdr0[7:0] + blocks) mod 256`.
- R9: In end-event mode, the chosen interval is `cfg_interval` when both that value and the block count are nonzero; otherwise it is the block count. `hdr0[7:0]` must equal `(stored + interval) mod 256`, and the stored counter then becomes `hdr0[7:0]`.
- R10: A counter mismatch sets `err_gap`, reports zero blocks, keeps `out_dbc` unchanged and halts the checker.
- R11: All error flags are sticky. A `restart` pulse clears the flags and the halt, and forgets the counter. `restart` wins over a `pkt_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Stream restart pulse |
| pkt_valid | input | 1 | Packet strobe |
| pkt_len | input | 16 | Packet byte length, header included |
| hdr0 | input | 32 | First header quadlet |
| hdr1 | input | 32 | Second header quadlet |
| cfg_sph | input | 1 | Expected source-packet-header bit |
| cfg_fmt | input | 6 | Expected format code |
| cfg_dbs | input | 8 | Configured block size in quadlets |
| cfg_max_len | input | 16 | Largest allowed byte length |
| cfg_no_eoh | input | 1 | Tolerate missing framing bits |
| cfg_force_dbs | input | 1 | Divide by cfg_dbs instead of the received size |
| cfg_end_event | input | 1 | Counter marks the end event |
| cfg_interval | input | 8 | Fixed counter step in end-event mode, 0 = use count |
| out_valid | output | 1 | Result strobe |
| out_blocks | output | 14 | Data blocks in the packet |
| out_syt | output | 16 | Timestamp field |
| out_dbc | output | 8 | Stored running counter |
| err_hdr | output | 1 | Sticky bad framing flag |
| err_proto | output | 1 | Sticky wrong protocol flag |
| err_dbs0 | output | 1 | Sticky zero block size flag |
| err_oversize | output | 1 | Sticky oversize flag |
| err_gap | output | 1 | Sticky counter break flag |
| halted | output | 1 | Fatal fault seen, packets dropped |

## Verification
Normal-mode streams with varying counts, including a counter wrap past 0xFF, show whether the counter follows count-plus-received-value. Packets that are empty, short, or carry the no-data code, each with the format both matching and not matching 0x10, separate the zero-count rules from the division path. End-event streams with the fixed interval on, then off, and with an empty packet between them, separate the three ways the interval can be chosen. Packets with bad framing, a wrong protocol, a zero block size, oversize lengths and counter breaks, each followed by further traffic and a restart, show which faults are sticky and which halt the checker. A restart coinciding with a packet shows that the restart takes priority.

// File: rtl/cip_rx_pkg.sv
`timescale 1ns/1ps
package cip_rx_pkg;
    // header field positions (fixed by the wire format)
    localparam int Q_EOH_BIT  = 31;
    localparam int SPH_BIT    = 10;
    localparam int DBS_LSB    = 16;
    localparam int FMT_LSB    = 24;
    localparam int FDF_LSB    = 16;
    localparam int DBC_W      = 8;
    localparam int SYT_W      = 16;
    localparam int FMT_W      = 6;
    localparam int DBS_W      = 8;
    localparam int FDF_W      = 8;
    localparam int HDR_BYTES  = 8;
    localparam int MIN_LEN    = 12;

    localparam logic [FMT_W-1:0] FMT_AUDIO = 6'h10;
    localparam logic [FDF_W-1:0] FDF_EMPTY = 8'hFF;

    typedef struct packed {
        logic hdr;
        logic proto;
        logic dbs0;
        logic oversize;
        logic gap;
    } cip_err_t;
endpackage

// File: rtl/cip_hdr_fields.sv
`timescale 1ns/1ps
module cip_hdr_fields
    import cip_rx_pkg::*;
(
    input  logic [31:0]       hdr0,
    input  logic [31:0]       hdr1,
    input  logic              cfg_no_eoh,
    input  logic              cfg_sph,
    input  logic [FMT_W-1:0]  cfg_fmt,
    output logic [DBS_W-1:0]  f_dbs,
    output logic [DBC_W-1:0]  f_dbc,
    output logic [FMT_W-1:0]  f_fmt,
    output logic [FDF_W-1:0]  f_fdf,
    output logic [SYT_W-1:0]  f_syt,
    output logic              frame_bad,
    output logic              proto_bad
);
    logic f_sph;
    logic eoh0, eoh1;
    logic unused_bits;

    always_comb begin
        f_dbs = hdr0[DBS_LSB +: DBS_W];
        f_dbc = hdr0[DBC_W-1:0];
        f_sph = hdr0[SPH_BIT];
        eoh0  = hdr0[Q_EOH_BIT];
        eoh1  = hdr1[Q_EOH_BIT];
        f_fmt = hdr1[FMT_LSB +: FMT_W];
        f_fdf = hdr1[FDF_LSB +: FDF_W];
        f_syt = hdr1[SYT_W-1:0];
        // framing: first quadlet must have the marker clear, second set
        frame_bad = !cfg_no_eoh && (eoh0 || !eoh1);
        proto_bad = (f_sph != cfg_sph) || (f_fmt != cfg_fmt);
    end

    assign unused_bits = ^{hdr0[30:24], hdr0[15:11], hdr0[9:8], hdr1[30]};
endmodule

// File: rtl/cip_blk_count.sv
`timescale 1ns/1ps
module cip_blk_count
    import cip_rx_pkg::*;
#(
    parameter int LEN_W = 16,
    localparam int BLK_W = LEN_W - 2
) (
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [DBS_W-1:0] rx_dbs,
    input  logic [FMT_W-1:0] rx_fmt,
    input  logic [FDF_W-1:0] rx_fdf,
    input  logic             cfg_force_dbs,
    input  logic [DBS_W-1:0] cfg_dbs,
    output logic [BLK_W-1:0] blocks,
    output logic             dbs_zero
);
    localparam logic [LEN_W-1:0] SHORT_LIM = LEN_W'(MIN_LEN);
    localparam logic [BLK_W-1:0] HDR_Q     = BLK_W'(HDR_BYTES / 4);

    logic             need_count;
    logic [DBS_W-1:0] divisor;
    logic [BLK_W-1:0] data_q;
    logic [BLK_W-1:0] quot;
    logic             unused_len;

    always_comb begin
        need_count = (pkt_len >= SHORT_LIM) &&
                     !((rx_fmt == FMT_AUDIO) && (rx_fdf == FDF_EMPTY));
        divisor    = cfg_force_dbs ? cfg_dbs : rx_dbs;
        data_q     = pkt_len[LEN_W-1:2] - HDR_Q;
        quot       = (divisor == '0) ? '0
                   : data_q / {{(BLK_W-DBS_W){1'b0}}, divisor};
        dbs_zero   = need_count && (rx_dbs == '0);
        blocks     = (need_count && !dbs_zero) ? quot : '0;
    end

    assign unused_len = ^pkt_len[1:0];
endmodule

// File: rtl/cip_dbc_judge.sv
`timescale 1ns/1ps
module cip_dbc_judge
    import cip_rx_pkg::*;
#(
    parameter int BLK_W = 14
) (
    input  logic             known,
    input  logic             end_mode,
    input  logic [DBC_W-1:0] cfg_interval,
    input  logic [DBC_W-1:0] dbc_rx,
    input  logic [DBC_W-1:0] dbc_q,
    input  logic [BLK_W-1:0] blocks,
    output logic             lost,
    output logic [DBC_W-1:0] dbc_next
);
    logic [DBC_W-1:0] blk_lo;
    logic [DBC_W-1:0] step;
    logic             unused_hi;

    assign blk_lo = blocks[DBC_W-1:0];

    generate
        if (BLK_W > DBC_W) begin : g_hi
            assign unused_hi = |blocks[BLK_W-1:DBC_W];
        end else begin : g_nohi
            assign unused_hi = 1'b0;
        end
    endgenerate

    always_comb begin
        step = ((blocks != '0) && (cfg_interval != '0)) ? cfg_interval : blk_lo;
        if (!known)
            lost = 1'b0;
        else if (!end_mode)
            lost = (dbc_rx != dbc_q);
        else
            lost = (dbc_rx != DBC_W'(dbc_q + step));
        dbc_next = end_mode ? dbc_rx : DBC_W'(dbc_rx + blk_lo);
    end
endmodule

// File: rtl/cip_rx_check.sv
`timescale 1ns/1ps
module cip_rx_check
    import cip_rx_pkg::*;
#(
    parameter int LEN_W = 16,
    localparam int BLK_W = LEN_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pkt_valid,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [31:0]      hdr0,
    input  logic [31:0]      hdr1,
    input  logic             cfg_sph,
    input  logic [FMT_W-1:0] cfg_fmt,
    input  logic [DBS_W-1:0] cfg_dbs,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             cfg_no_eoh,
    input  logic             cfg_force_dbs,
    input  logic             cfg_end_event,
    input  logic [DBC_W-1:0] cfg_interval,
    output logic             out_valid,
    output logic [BLK_W-1:0] out_blocks,
    output logic [SYT_W-1:0] out_syt,
    output logic [DBC_W-1:0] out_dbc,
    output logic             err_hdr,
    output logic             err_proto,
    output logic             err_dbs0,
    output logic             err_oversize,
    output logic             err_gap,
    output logic             halted
);
    typedef struct packed {
        logic             vld;
        logic [BLK_W-1:0] blocks;
        logic [SYT_W-1:0] syt;
        logic [DBC_W-1:0] dbc;
        logic             known;
        logic             halt;
        cip_err_t         err;
    } state_t;

    state_t st_d, st_q;

    logic [DBS_W-1:0] f_dbs;
    logic [DBC_W-1:0] f_dbc;
    logic [FMT_W-1:0] f_fmt;
    logic [FDF_W-1:0] f_fdf;
    logic [SYT_W-1:0] f_syt;
    logic             frame_bad, proto_bad;
    logic [BLK_W-1:0] blk_cnt;
    logic             dbs_zero;
    logic             lost;
    logic [DBC_W-1:0] dbc_next;
    logic             too_long;

    cip_hdr_fields u_fields (
        .hdr0       (hdr0),
        .hdr1       (hdr1),
        .cfg_no_eoh (cfg_no_eoh),
        .cfg_sph    (cfg_sph),
        .cfg_fmt    (cfg_fmt),
        .f_dbs      (f_dbs),
        .f_dbc      (f_dbc),
        .f_fmt      (f_fmt),
        .f_fdf      (f_fdf),
        .f_syt      (f_syt),
        .frame_bad  (frame_bad),
        .proto_bad  (proto_bad)
    );

    cip_blk_count #(.LEN_W(LEN_W)) u_count (
        .pkt_len       (pkt_len),
        .rx_dbs        (f_dbs),
        .rx_fmt        (f_fmt),
        .rx_fdf        (f_fdf),
        .cfg_force_dbs (cfg_force_dbs),
        .cfg_dbs       (cfg_dbs),
        .blocks        (blk_cnt),
        .dbs_zero      (dbs_zero)
    );

    cip_dbc_judge #(.BLK_W(BLK_W)) u_judge (
        .known        (st_q.known),
        .end_mode     (cfg_end_event),
        .cfg_interval (cfg_interval),
        .dbc_rx       (f_dbc),
        .dbc_q        (st_q.dbc),
        .blocks       (blk_cnt),
        .lost         (lost),
        .dbc_next     (dbc_next)
    );

    assign too_long = (pkt_len > cfg_max_len);

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (restart) begin
            st_d.err   = '0;
            st_d.halt  = 1'b0;
            st_d.known = 1'b0;
        end else if (pkt_valid && !st_q.halt) begin
            st_d.vld    = 1'b1;
            st_d.blocks = '0;
            st_d.syt    = f_syt;
            if (too_long) begin
                st_d.err.oversize = 1'b1;
                st_d.halt         = 1'b1;
            end else if (frame_bad) begin
                st_d.err.hdr = 1'b1;
            end else if (proto_bad) begin
                st_d.err.proto = 1'b1;
            end else if (dbs_zero) begin
                st_d.err.dbs0 = 1'b1;
                st_d.halt     = 1'b1;
            end else if (lost) begin
                st_d.err.gap = 1'b1;
                st_d.halt    = 1'b1;
            end else begin
                st_d.blocks = blk_cnt;
                st_d.dbc    = dbc_next;
                st_d.known  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.vld;
    assign out_blocks   = st_q.blocks;
    assign out_syt      = st_q.syt;
    assign out_dbc      = st_q.dbc;
    assign err_hdr      = st_q.err.hdr;
    assign err_proto    = st_q.err.proto;
    assign err_dbs0     = st_q.err.dbs0;
    assign err_oversize = st_q.err.oversize;
    assign err_gap      = st_q.err.gap;
    assign halted       = st_q.halt;
endmodule

// File: rtl/cip_rx_check_sva.sv
`timescale 1ns/1ps
module cip_rx_check_sva #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic             pkt_valid,
    input logic             out_valid,
    input logic [LEN_W-3:0] out_blocks,
    input logic [7:0]       out_dbc,
    input logic             err_hdr,
    input logic             err_dbs0,
    input logic             err_oversize,
    input logic             err_gap,
    input logic             halted
);
    // R1
    result_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(pkt_valid) && !$past(restart) && !$past(halted)));
    // R2
    halted_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !restart) |=> !out_valid);
    // R3
    bad_frame_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_hdr) |-> (out_valid && out_blocks == '0));
    // R6
    halt_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (err_oversize || err_dbs0 || err_gap));
    // R8
    dbc_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_dbc));
    // R10
    gap_keeps_dbc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_gap) |-> ($stable(out_dbc) && halted && out_blocks == '0));
    // R11
    hdr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_hdr && !restart) |=> err_hdr);
    // R11
    gap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_gap && !restart) |=> err_gap);
endmodule

bind cip_rx_check cip_rx_check_sva #(.LEN_W(LEN_W)) u_sva (.*);

// File: tb/cip_rx_check_bench.sv
`timescale 1ns/1ps
module cip_rx_check_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [15:0] pkt_len = '0;
    logic [31:0] hdr0 = '0, hdr1 = '0;
    logic        cfg_sph = 1'b0;
    logic [5:0]  cfg_fmt = 6'h10;
    logic [7:0]  cfg_dbs = 8'd2;
    logic [15:0] cfg_max_len = 16'd1024;
    logic        cfg_no_eoh = 1'b0, cfg_force_dbs = 1'b0, cfg_end_event = 1'b0;
    logic [7:0]  cfg_interval = 8'd0;
    logic        out_valid;
    logic [13:0] out_blocks;
    logic [15:0] out_syt;
    logic [7:0]  out_dbc;
    logic        err_hdr, err_proto, err_dbs0, err_oversize, err_gap, halted;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cip_rx_check u_cip_rx_check (.*);

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_valid, m_blocks, m_syt, m_dbc;
    bit  m_known, m_halt;
    bit  m_hdr, m_proto, m_dbs0, m_over, m_gap;

    always @(posedge clk) begin
        int nb, d, rx, iv;
        bit lost;
        if (!rst_n) begin
            m_valid = 0; m_blocks = 0; m_syt = 0; m_dbc = 0;
            m_known = 0; m_halt = 0;
            m_hdr = 0; m_proto = 0; m_dbs0 = 0; m_over = 0; m_gap = 0;
        end else begin
            m_valid = 0;
            if (restart) begin
                m_hdr = 0; m_proto = 0; m_dbs0 = 0; m_over = 0; m_gap = 0;
                m_halt = 0; m_known = 0;
            end else if (pkt_valid && !m_halt) begin
                m_valid = 1; m_blocks = 0; m_syt = int'(hdr1[15:0]);
                if (int'(pkt_len) > int'(cfg_max_len)) begin
                    m_over = 1; m_halt = 1;
                end else if (!cfg_no_eoh && (hdr0[31] || !hdr1[31])) begin
                    m_hdr = 1;
                end else if (hdr0[10] != cfg_sph || hdr1[29:24] != cfg_fmt) begin
                    m_proto = 1;
                end else begin
                    nb = 0;
                    if (pkt_len < 12 || (hdr1[29:24] == 6'h10 && hdr1[23:16] == 8'hFF))
                        nb = 0;
                    else if (hdr0[23:16] == 0)
                        nb = -1;
                    else begin
                        d = cfg_force_dbs ? int'(cfg_dbs) : int'(hdr0[23:16]);
                        nb = (int'(pkt_len) / 4 - 2) / d;
                    end
                    if (nb < 0) begin
                        m_dbs0 = 1; m_halt = 1;
                    end else begin
                        rx = int'(hdr0[7:0]);
                        if (!m_known) lost = 0;
                        else if (!cfg_end_event) lost = (rx != m_dbc);
                        else begin
                            iv = (nb > 0 && cfg_interval != 0) ? int'(cfg_interval) : nb;
                            lost = (rx != ((m_dbc + iv) % 256));
                        end
                        if (lost) begin
                            m_gap = 1; m_halt = 1;
                        end else begin
                            m_blocks = nb;
                            m_dbc = cfg_end_event ? rx : (rx + nb) % 256;
                            m_known = 1;
                        end
                    end
                end
            end
        end
    end

    // every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 out_valid", out_valid, m_valid);
            if (m_valid) begin
                check("R5 out_blocks", out_blocks, m_blocks);
                check("R1 out_syt", out_syt, m_syt);
            end
            check("R8/R9 out_dbc", out_dbc, m_dbc);
            check("R3 err_hdr", err_hdr, m_hdr);
            check("R4 err_proto", err_proto, m_proto);
            check("R6 err_dbs0", err_dbs0, m_dbs0);
            check("R2 err_oversize", err_oversize, m_over);
            check("R10 err_gap", err_gap, m_gap);
            check("R11 halted", halted, m_halt);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] q0(input bit sph, input int dbs, input int dbc);
        return {2'b00, 6'd5, 8'(dbs), 5'd0, sph, 2'd0, 8'(dbc)};
    endfunction
    function automatic logic [31:0] q1(input bit eoh, input int fmt, input int fdf, input int syt);
        return {eoh, 1'b0, 6'(fmt), 8'(fdf), 16'(syt)};
    endfunction

    task automatic send(input int len, input logic [31:0] h0, input logic [31:0] h1);
        @(negedge clk);
        pkt_valid = 1; pkt_len = 16'(len); hdr0 = h0; hdr1 = h1;
        @(negedge clk);
        pkt_valid = 0;
    endtask

    task automatic good(input int nblk, input int dbc, input int syt);
        send(8 + 8 * nblk, q0(0, 2, dbc), q1(1, 6'h10, 2, syt));
    endtask

    task automatic do_restart;
        @(negedge clk); restart = 1;
        @(negedge clk); restart = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int dbc;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state, R11
        check("R11 reset out_valid", out_valid, 0);
        check("R11 reset flags", {err_hdr, err_proto, err_dbs0, err_oversize, err_gap, halted}, 0);

        // first packet, no continuity test: R7, R5, R1
        good(3, 8'h37, 16'h1234);
        check("R7 first blocks", out_blocks, 3);
        check("R7 first dbc", out_dbc, 8'h3A);
        check("R1 syt", out_syt, 16'h1234);
        good(4, 8'h3A, 16'h2000);
        check("R8 next dbc", out_dbc, 8'h3E);
        // no-data code and short packet: R5
        send(40, q0(0, 2, 8'h3E), q1(1, 6'h10, 8'hFF, 16'hFFFF));
        check("R5 nodata blocks", out_blocks, 0);
        send(8, q0(0, 2, 8'h3E), q1(1, 6'h10, 2, 16'h0));
        check("R5 short blocks", out_blocks, 0);
        check("R5 short dbc", out_dbc, 8'h3E);
        // 0xFF fdf with another format still counts: R5
        cfg_fmt = 6'h20;
        send(24, q0(0, 2, 8'h3E), q1(1, 6'h20, 8'hFF, 16'h0));
        check("R5 other fmt blocks", out_blocks, 2);
        cfg_fmt = 6'h10;

        // framing: R3
        send(24, q0(0, 2, 8'h40) | 32'h8000_0000, q1(1, 6'h10, 2, 0));
        check("R3 err_hdr", err_hdr, 1);
        check("R3 dbc kept", out_dbc, 8'h40);
        cfg_no_eoh = 1;
        send(24, q0(0, 2, 8'h40) | 32'h8000_0000, q1(0, 6'h10, 2, 0));
        check("R3 tolerated blocks", out_blocks, 2);
        cfg_no_eoh = 0;

        // protocol: R4
        send(24, q0(1, 2, 8'h42), q1(1, 6'h10, 2, 0));
        check("R4 sph err", err_proto, 1);
        check("R4 blocks", out_blocks, 0);
        send(24, q0(0, 2, 8'h42), q1(1, 6'h11, 2, 0));
        check("R4 dbc kept", out_dbc, 8'h42);

        // forced block size: R6
        cfg_force_dbs = 1;
        send(24, q0(0, 4, 8'h42), q1(1, 6'h10, 2, 0));
        check("R6 forced blocks", out_blocks, 2);
        cfg_force_dbs = 0;

        // restart clears flags; wrap of counter: R11, R8
        do_restart;
        check("R11 flags cleared", {err_hdr, err_proto}, 0);
        good(3, 8'hFD, 1);
        check("R8 wrap dbc", out_dbc, 8'h00);
        dbc = 0;
        for (int i = 0; i < 20; i++) begin
            good(i % 5, dbc, i);
            dbc = (dbc + i % 5) % 256;
        end
        check("R8 run dbc", out_dbc, dbc);

        // break: R10, R2
        good(2, (dbc + 5) % 256, 9);
        check("R10 gap", err_gap, 1);
        check("R10 halted", halted, 1);
        check("R10 dbc kept", out_dbc, dbc);
        good(2, dbc, 9);
        check("R2 halted drops", out_valid, 0);

        // restart coinciding with a packet: R11
        @(negedge clk);
        restart = 1; pkt_valid = 1; pkt_len = 24; hdr0 = q0(0, 2, 1); hdr1 = q1(1, 6'h10, 2, 0);
        @(negedge clk);
        restart = 0; pkt_valid = 0;
        check("R11 restart wins", out_valid, 0);
        check("R11 gap cleared", err_gap, 0);

        // zero block size: R6
        send(8, q0(0, 0, 8'h10), q1(1, 6'h10, 2, 0));
        check("R6 no count no error", err_dbs0, 0);
        send(24, q0(0, 0, 8'h10), q1(1, 6'h10, 2, 0));
        check("R6 dbs zero", err_dbs0, 1);
        check("R6 halted", halted, 1);
        do_restart;

        // oversize boundary: R2
        cfg_max_len = 64;
        good(7, 8'h20, 0);
        check("R2 at limit", out_blocks, 7);
        send(68, q0(0, 2, 8'h27), q1(1, 6'h10, 2, 0));
        check("R2 oversize", err_oversize, 1);
        check("R2 oversize blocks", out_blocks, 0);
        do_restart;
        cfg_max_len = 1024;

        // end-event mode: R9
        cfg_end_event = 1; cfg_interval = 8;
        good(8, 8'h10, 0);
        check("R9 first dbc", out_dbc, 8'h10);
        good(8, 8'h18, 0);
        check("R9 step dbc", out_dbc, 8'h18);
        good(0, 8'h18, 0);
        check("R9 empty keeps", err_gap, 0);
        good(2, 8'h20, 0);
        check("R9 fixed interval", out_dbc, 8'h20);
        cfg_interval = 0;
        good(2, 8'h22, 0);
        check("R9 count interval", out_dbc, 8'h22);
        good(2, 8'h23, 0);
        check("R9 break", err_gap, 1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule